// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Access-Rights Check

This block translates the virtual page number of a processor access into a physical page number and, in the same lookup, decides whether the access is allowed. Each line holds a valid bit, an address tag and a complete page table entry: the physical page number plus four rights bits (supervisor-only, readable, writable, executable). A lookup is combinational. The response to a request appears in the same cycle as the request strobe. A hit gives the physical address unless the rights check fails. A miss tells the requester to obtain the entry from a page table walker.

Completed entries come back through a fill port that uses a valid/ready handshake. A fill transfers on a clock edge where both `fill_valid` and `fill_ready` are high. `fill_ready` drops only in a cycle where `flush` is high. A walker facing a low ready must hold its entry and valid steady until ready returns. The request side is a plain strobe with no back-pressure, because a lookup always completes in its own cycle. A single-cycle `flush` input invalidates every line. Defaults are a 32-bit virtual and physical address, 4 KB pages, 4 sets and 2 ways.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, and in every cycle after a flush, no line is valid, so every lookup reports a miss (`rsp_hit`=0, `rsp_fault`=0, `rsp_pa`=0).
- R2: The virtual page number is `req_va[31:12]`. Its low two bits `req_va[13:12]` pick the set, and `req_va[31:14]` is the tag. A lookup hits when a valid line in that set has an equal tag.
- R3: On a permitted hit, `rsp_pa` is the stored physical page number in bits 31:12 and `req_va[11:0]` unchanged in bits 11:0.
- R4: A fill writes `fill_vpn` (set `fill_vpn[1:0]`, tag `fill_vpn[19:2]`), the physical page and the rights. A lookup in any later cycle hits it. If a valid line in the set already holds that tag, the fill overwrites that line instead of taking a new one.
- R5: A fill of a new tag takes the lowest-numbered invalid way of its set. When every way is valid, it takes the least recently used way.
- R6: A hit makes the hit way most recently used, whether or not it faults. A fill makes the filled way most recently used. When a fill and a hit touch the same set in one cycle, the fill decides the order.
- R7: A user-mode access (`req_user`=1) that hits a supervisor-only line faults. A supervisor-mode access may use both kinds of page.
- R8: Access codes on `req_acc` are 00 read, 01 write, 10 fetch, and 11 which is treated as read. A write to a page without write right, a fetch from a page without execute right, and a read from a page without read right each fault.
- R9: A faulting hit reports `rsp_hit`=1 and `rsp_fault`=1 with `rsp_pa`=0. A miss never reports a fault.
- R10: A lookup of the same virtual page that a fill transfers in that same cycle reports a miss.
- R11: When `flush` is high, every line is invalid from the next cycle on, a lookup in that cycle misses, and `fill_ready` is low so no fill is taken.
- R12: While `req_valid` is low, `rsp_hit`, `rsp_fault` and `rsp_pa` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate every line at the next edge |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address of the access |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| rsp_hit | output | 1 | A valid line matched this cycle's request |
| rsp_fault | output | 1 | The hit line forbids this access |
| rsp_pa | output | 32 | Physical address on a permitted hit, else zero |
| fill_valid | input | 1 | Fill entry offered |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_sup | input | 1 | Supervisor-only page |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| fill_ex | input | 1 | Execute allowed |

## Verification
The hardest state to reach from the ports is a full set under replacement pressure. In that state, a recent hit must steer the next fill away from one way, and a fill and a hit may touch the same set in the same cycle. Uniformly random 20-bit page numbers almost never share a set and tag pair. The random stimulus therefore draws tags from a pool of six and sets from all four. This keeps sets full, forces evictions, re-fills pages that are already present, and often lines up a fill and a lookup on one page. Directed steps before the random phase walk one set through invalid-first placement and an LRU eviction. They also walk each fault condition and a flush with a lookup in its cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic sup;
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 18,
  parameter int PPN_W = 20
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              wr_en,
  input  logic [$clog2(SETS)-1:0]           wr_set,
  input  logic [$clog2(WAYS)-1:0]           wr_way,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic [PPN_W-1:0]                  wr_ppn,
  input  perm_t                             wr_perm,
  input  logic [$clog2(SETS)-1:0]           a_set,
  output logic [WAYS-1:0]                   a_vld,
  output logic [WAYS-1:0][TAG_W-1:0]        a_tag,
  output logic [WAYS-1:0][PPN_W-1:0]        a_ppn,
  output perm_t [WAYS-1:0]                  a_perm,
  input  logic [$clog2(SETS)-1:0]           b_set,
  output logic [WAYS-1:0]                   b_vld,
  output logic [WAYS-1:0][TAG_W-1:0]        b_tag
);

  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]          ppn_q  [SETS][WAYS];
  perm_t                     perm_q [SETS][WAYS];

  // Valid bits carry reset; a clear beats a write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  // Payload needs no reset: it is only read behind a valid bit.
  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      ppn_q[wr_set][wr_way]  <= wr_ppn;
      perm_q[wr_set][wr_way] <= wr_perm;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign a_vld[w]  = vld_q[a_set][w];
    assign a_tag[w]  = tag_q[a_set][w];
    assign a_ppn[w]  = ppn_q[a_set][w];
    assign a_perm[w] = perm_q[a_set][w];
    assign b_vld[w]  = vld_q[b_set][w];
    assign b_tag[w]  = tag_q[b_set][w];
  end

  // R11: a flush leaves nothing valid
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

  // R4: an accepted fill lands in a valid line
  a_r4_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> vld_q[$past(wr_set)][$past(wr_way)]);

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 18
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             way_hit,
  output logic                        any_hit,
  output logic [$clog2(WAYS)-1:0]     hit_idx
);

  localparam int IDX_W = $clog2(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld[w] && (tags[w] == key);
  end

  assign any_hit = |way_hit;

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_idx = IDX_W'(w);
    end
  end

  // R4: fill placement never leaves two lines with one tag in a set
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int SETS = 4,
  parameter int WAYS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [$clog2(SETS)-1:0]  touch_set,
  input  logic [$clog2(WAYS)-1:0]  touch_way,
  input  logic                     fill_en,
  input  logic [$clog2(SETS)-1:0]  fill_set,
  input  logic [$clog2(WAYS)-1:0]  fill_way,
  input  logic [$clog2(SETS)-1:0]  q_set,
  output logic [$clog2(WAYS)-1:0]  victim
);

  localparam int SET_W = $clog2(SETS);
  localparam int IDX_W = $clog2(WAYS);

  logic [IDX_W-1:0] vic_q [SETS];

  if (WAYS == 2) begin : g_lru
    // One bit per set names the least recently used way.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) vic_q[s] <= '0;
      end else begin
        for (int s = 0; s < SETS; s++) begin
          if (fill_en && (fill_set == SET_W'(s))) begin
            vic_q[s] <= ~fill_way;
          end else if (touch_en && (touch_set == SET_W'(s))) begin
            vic_q[s] <= ~touch_way;
          end
        end
      end
    end

    // R6: the way just filled is not the next victim
    a_r6_fill_mru: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vic_q[$past(fill_set)] != $past(fill_way)));

    // R6: a hit without a competing fill protects the hit way
    a_r6_hit_mru: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_en && !(fill_en && (fill_set == touch_set)))
        |=> (vic_q[$past(touch_set)] != $past(touch_way)));
  end else begin : g_rr
    // Wider sets fall back to a per-set rotating pointer.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) vic_q[s] <= '0;
      end else begin
        for (int s = 0; s < SETS; s++) begin
          if (fill_en && (fill_set == SET_W'(s))) begin
            vic_q[s] <= (fill_way == IDX_W'(WAYS - 1)) ? '0 : fill_way + 1'b1;
          end
        end
      end
    end
  end

  assign victim = vic_q[q_set];

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  acc_e  acc,
  input  logic  user,
  input  perm_t perm,
  output logic  fault
);

  logic granted;

  always_comb begin
    unique case (acc)
      ACC_STORE: granted = perm.wr;
      ACC_FETCH: granted = perm.ex;
      default:   granted = perm.rd;
    endcase
    fault = !granted || (user && perm.sup);
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int PPN_W = 20,
  parameter int SETS  = 4,
  parameter int WAYS  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_va,
  input  logic [1:0]              req_acc,
  input  logic                    req_user,
  output logic                    rsp_hit,
  output logic                    rsp_fault,
  output logic [PPN_W+OFS_W-1:0]  rsp_pa,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [VA_W-OFS_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]        fill_ppn,
  input  logic                    fill_sup,
  input  logic                    fill_rd,
  input  logic                    fill_wr,
  input  logic                    fill_ex
);

  localparam int VPN_W = VA_W - OFS_W;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int IDX_W = $clog2(WAYS);
  localparam int PA_W  = PPN_W + OFS_W;

  // Request-side decode
  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  assign lk_vpn = req_va[VA_W-1:OFS_W];
  assign lk_set = lk_vpn[SET_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W];

  // Fill-side decode and handshake
  logic [SET_W-1:0] fl_set;
  logic [TAG_W-1:0] fl_tag;
  logic             fill_fire;
  perm_t            fl_perm;
  assign fl_set     = fill_vpn[SET_W-1:0];
  assign fl_tag     = fill_vpn[VPN_W-1:SET_W];
  assign fill_ready = !flush;
  assign fill_fire  = fill_valid && fill_ready;
  assign fl_perm    = '{sup: fill_sup, rd: fill_rd, wr: fill_wr, ex: fill_ex};

  logic [WAYS-1:0]             lk_vld, fl_vld;
  logic [WAYS-1:0][TAG_W-1:0]  lk_tags, fl_tags;
  logic [WAYS-1:0][PPN_W-1:0]  lk_ppns;
  perm_t [WAYS-1:0]            lk_perms;
  logic [IDX_W-1:0]            fl_way;

  tlb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush),
    .wr_en   (fill_fire),
    .wr_set  (fl_set),
    .wr_way  (fl_way),
    .wr_tag  (fl_tag),
    .wr_ppn  (fill_ppn),
    .wr_perm (fl_perm),
    .a_set   (lk_set),
    .a_vld   (lk_vld),
    .a_tag   (lk_tags),
    .a_ppn   (lk_ppns),
    .a_perm  (lk_perms),
    .b_set   (fl_set),
    .b_vld   (fl_vld),
    .b_tag   (fl_tags)
  );

  // Way compare for the lookup
  logic [WAYS-1:0]  lk_way_hit;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_lk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (lk_vld),
    .tags    (lk_tags),
    .key     (lk_tag),
    .way_hit (lk_way_hit),
    .any_hit (lk_any),
    .hit_idx (lk_idx)
  );

  // Way compare for the fill: a page already present is rewritten in place
  logic [WAYS-1:0]  fl_way_hit;
  logic             fl_any;
  logic [IDX_W-1:0] fl_idx;

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_fl (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (fl_vld),
    .tags    (fl_tags),
    .key     (fl_tag),
    .way_hit (fl_way_hit),
    .any_hit (fl_any),
    .hit_idx (fl_idx)
  );

  // Lowest-numbered invalid way of the fill set
  logic             fl_has_free;
  logic [IDX_W-1:0] fl_free;
  always_comb begin
    fl_has_free = 1'b0;
    fl_free     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!fl_vld[w]) begin
        fl_has_free = 1'b1;
        fl_free     = IDX_W'(w);
      end
    end
  end

  logic             lk_hit;
  logic [IDX_W-1:0] lru_way;

  tlb_repl #(.SETS(SETS), .WAYS(WAYS)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (lk_hit),
    .touch_set (lk_set),
    .touch_way (lk_idx),
    .fill_en   (fill_fire),
    .fill_set  (fl_set),
    .fill_way  (fl_way),
    .q_set     (fl_set),
    .victim    (lru_way)
  );

  // Placement order: existing line, then free way, then LRU victim
  assign fl_way = fl_any ? fl_idx : (fl_has_free ? fl_free : lru_way);

  // Hit qualification: a page being filled this cycle, or a flush, reads as a miss
  logic same_page;
  assign same_page = fill_fire && (fill_vpn == lk_vpn);
  assign lk_hit    = req_valid && lk_any && !flush && !same_page;

  logic perm_fault;
  tlb_perm u_perm (
    .acc   (acc_e'(req_acc)),
    .user  (req_user),
    .perm  (lk_perms[lk_idx]),
    .fault (perm_fault)
  );

  assign rsp_hit   = lk_hit;
  assign rsp_fault = lk_hit && perm_fault;
  assign rsp_pa    = (lk_hit && !perm_fault) ? {lk_ppns[lk_idx], req_va[OFS_W-1:0]} : '0;

  // R9: a fault always comes with a hit and withholds the address
  a_r9_fault_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  a_r9_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_pa == '0));

  // R12: no request, no response
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_hit && !rsp_fault && (rsp_pa == '0)));

  // R10: a page in flight through the fill port is not seen by the lookup
  a_r10_fill_race_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && (fill_vpn == req_va[VA_W-1:OFS_W])) |-> !rsp_hit);

  // R11: a lookup in the flush cycle misses, and the cycle after finds nothing
  a_r11_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!rsp_hit && !fill_ready));
  a_r1_after_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rsp_hit);

  // R3: a granted translation keeps the page offset
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !rsp_fault) |-> (rsp_pa[OFS_W-1:0] == req_va[OFS_W-1:0]));

endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        rsp_hit, rsp_fault, fill_ready;
  logic [31:0] rsp_pa;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_sup = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, fill_ex = 1'b0;

  always #2.5 clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc), .req_user(req_user),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_sup(fill_sup), .fill_rd(fill_rd),
    .fill_wr(fill_wr), .fill_ex(fill_ex)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference state built from the requirements
  bit        m_vld  [4][2];
  bit [17:0] m_tag  [4][2];
  bit [19:0] m_ppn  [4][2];
  bit [3:0]  m_perm [4][2];   // {sup, rd, wr, ex}
  bit        m_vic  [4];

  function automatic bit perm_fault(input bit [3:0] p, input bit [1:0] acc, input bit usr);
    bit ok;
    case (acc)
      2'b01:   ok = p[1];
      2'b10:   ok = p[0];
      default: ok = p[2];
    endcase
    return !ok || (usr && p[3]);
  endfunction

  task automatic check(input string rq, input bit eh, input bit ef, input bit [31:0] ep, input bit er);
    checks++;
    if (rsp_hit !== eh || rsp_fault !== ef || rsp_pa !== ep || fill_ready !== er) begin
      failures++;
      $display("FAIL %s hit=%0b exp %0b fault=%0b exp %0b pa=%h exp %h ready=%0b exp %0b",
               rq, rsp_hit, eh, rsp_fault, ef, rsp_pa, ep, fill_ready, er);
    end
  endtask

  // One cycle: drive at the falling edge, check before the rising edge, then advance the model.
  task automatic step(input string rq, input bit rv, input bit [31:0] va, input bit [1:0] acc,
                      input bit usr, input bit fv, input bit [19:0] fvpn, input bit [19:0] fppn,
                      input bit [3:0] fperm, input bit fl);
    bit [1:0]  s, fs;
    bit [17:0] t, ft;
    bit        any, eh, ef, fire;
    int        hw, fw;
    bit [31:0] ep;
    req_valid = rv; req_va = va; req_acc = acc; req_user = usr;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
    {fill_sup, fill_rd, fill_wr, fill_ex} = fperm;
    flush = fl;
    #1;
    s = va[13:12]; t = va[31:14];
    any = 0; hw = 0;
    for (int w = 0; w < 2; w++) if (m_vld[s][w] && m_tag[s][w] == t) begin any = 1; hw = w; end
    fire = fv && !fl;
    eh = rv && any && !fl && !(fire && fvpn == va[31:12]);
    ef = eh && perm_fault(m_perm[s][hw], acc, usr);
    ep = (eh && !ef) ? {m_ppn[s][hw], va[11:0]} : 32'h0;
    check(rq, eh, ef, ep, !fl);
    @(posedge clk);
    fs = fvpn[1:0]; ft = fvpn[19:2];
    if (fl) begin
      for (int a = 0; a < 4; a++) for (int w = 0; w < 2; w++) m_vld[a][w] = 0;
    end else begin
      if (fire) begin
        fw = -1;
        for (int w = 0; w < 2; w++) if (m_vld[fs][w] && m_tag[fs][w] == ft) fw = w;
        if (fw < 0) for (int w = 1; w >= 0; w--) if (!m_vld[fs][w]) fw = w;
        if (fw < 0) fw = m_vic[fs];
        m_vld[fs][fw] = 1; m_tag[fs][fw] = ft; m_ppn[fs][fw] = fppn; m_perm[fs][fw] = fperm;
        m_vic[fs] = (fw == 0);
      end
      if (eh && !(fire && fs == s)) m_vic[s] = (hw == 0);
    end
    @(negedge clk);
  endtask

  task automatic look(input string rq, input bit [31:0] va, input bit [1:0] acc, input bit usr);
    step(rq, 1, va, acc, usr, 0, 20'h0, 20'h0, 4'h0, 0);
  endtask

  task automatic fill(input string rq, input bit [19:0] vpn, input bit [19:0] ppn, input bit [3:0] p);
    step(rq, 0, 32'h0, 2'b00, 0, 1, vpn, ppn, p, 0);
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 4; a++) begin
      m_vic[a] = 0;
      for (int w = 0; w < 2; w++) begin m_vld[a][w] = 0; m_tag[a][w] = 0; m_ppn[a][w] = 0; m_perm[a][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing valid after reset
    look("R1 reset miss", 32'h0000_5123, 2'b00, 0);
    // R12: idle request is quiet
    step("R12 idle", 0, 32'h0000_5123, 2'b00, 0, 0, 20'h0, 20'h0, 4'h0, 0);
    // R4 / R3 / R2: fill then permitted read
    fill("R4 fill", 20'h00005, 20'hABCDE, 4'b0111);
    look("R3 pa compose", 32'h0000_5123, 2'b00, 1);
    look("R2 other tag same set misses", 32'h0004_5123, 2'b00, 0);
    step("R12 idle after fill", 0, 32'h0000_5FFF, 2'b00, 0, 0, 20'h0, 20'h0, 4'h0, 0);
    // R4: refill of a present page rewrites in place
    fill("R4 rewrite", 20'h00005, 20'h12345, 4'b0111);
    look("R4 rewritten ppn", 32'h0000_5ABC, 2'b11, 0);
    // R10: same-page fill and lookup in one cycle
    step("R10 race miss", 1, 32'h0000_9010, 2'b00, 0, 1, 20'h00009, 20'h00777, 4'b0100, 0);
    look("R10 hit next cycle", 32'h0000_9010, 2'b00, 0);
    // R5 / R6: set 2 placement and LRU eviction
    fill("R5 first way", 20'h00012, 20'h0AAAA, 4'b0100);
    fill("R5 second way", 20'h00022, 20'h0BBBB, 4'b0100);
    look("R6 touch first", 32'h0001_2000, 2'b00, 0);
    fill("R5 evict lru", 20'h00032, 20'h0CCCC, 4'b0100);
    look("R5 survivor hits", 32'h0001_2004, 2'b00, 0);
    look("R5 victim gone", 32'h0002_2004, 2'b00, 0);
    look("R5 new line hits", 32'h0003_2008, 2'b00, 0);
    // R7 / R8: rights
    fill("R7 sup page", 20'h00103, 20'h0F00F, 4'b1111);
    look("R7 user on sup", 32'h0010_3000, 2'b00, 1);
    look("R7 sup on sup", 32'h0010_3000, 2'b10, 0);
    fill("R8 ro page", 20'h00200, 20'h0D00D, 4'b0100);
    look("R8 write no w", 32'h0020_0010, 2'b01, 0);
    look("R8 fetch no x", 32'h0020_0010, 2'b10, 0);
    look("R8 read ok", 32'h0020_0010, 2'b00, 1);
    fill("R8 xo page", 20'h00300, 20'h0E00E, 4'b0001);
    look("R8 read no r", 32'h0030_0020, 2'b00, 0);
    look("R9 reserved code as read", 32'h0030_0020, 2'b11, 0);
    look("R8 fetch ok", 32'h0030_0020, 2'b10, 0);
    // R11: flush with a lookup and a fill in its cycle
    step("R11 flush cycle", 1, 32'h0000_5ABC, 2'b00, 0, 1, 20'h00400, 20'h00400, 4'b0111, 1);
    look("R1 after flush", 32'h0000_5ABC, 2'b00, 0);
    look("R11 fill refused", 32'h0040_0000, 2'b00, 0);

    // Random phase over a small tag pool
    for (int i = 0; i < 3000; i++) begin
      bit [19:0] v1, v2;
      v1 = {16'(($urandom % 6)), 2'b00, 2'($urandom)};
      v1 = {v1[19:2], v1[1:0]};
      v1[19:2] = 18'($urandom % 6);
      v2[19:2] = 18'($urandom % 6);
      v2[1:0]  = 2'($urandom);
      if (($urandom % 4) == 0) v2 = v1;
      step("R2 random", ($urandom % 5) != 0, {v1, 12'($urandom)}, 2'($urandom), 1'($urandom),
           ($urandom % 10) < 3, v2, 20'($urandom), 4'($urandom), ($urandom % 100) == 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule